// File: doc/BRIEF.md
# Multi-Layer Round-Robin Bus Matrix

This block joins three bus masters (a processor data port and two DMA engines) to a set of slave ports such as flash, on-chip SRAM, an external memory controller and the system bus toward the peripheral bridges. Each master presents a request, an address and transfer attributes (write flag, size, write data). An address decoder turns the top bits of each address into a one-hot slave select. Every slave port has its own round-robin arbiter, so masters aimed at different slaves all move forward in the same cycle. Only masters that meet on one slave have to take turns.

A grant covers exactly one transfer cycle, and the slave is arbitrated again on the next cycle. A master that keeps its request up on a contended slave is therefore served at least once in every three cycles. A grant is combinational: with no competitor, a master is served in the cycle it asks. An address that hits no slave region is answered at once with an error response and never reaches a slave port. Pipelined address/data phases, bursts and bridges are not modelled. Read data comes back combinationally from the slave in the granted cycle.

Top module: `xbar_rr_matrix`

## Requirements
- R1: Masters whose addresses decode to different slaves are all given `m_ready` in the same cycle, and each slave port carries its own master's transfer.
- R2: A request that no other master contends for is granted in the cycle it is raised, and again in every following cycle it is held, with no idle cycle inserted.
- R3: Masters contending for one slave are served in rotation by master index. Each arbiter starts the next search at the index just above the master it last served, wrapping to 0.
- R4: A grant lasts one cycle. A master holding a request on a contended slave waits at most one cycle per competing master, so it is served at least once in every N_MST cycles.
- R5: A slave port serves at most one master per cycle. While `s_valid` is high it shows that master's index on `s_master` and its address, write flag, size and write data.
- R6: The slave index is the top REGION_W address bits. A region value of N_SLV or more is unmapped. Such a request gets `m_ready` and `m_err` together in the same cycle, and no slave port asserts `s_valid` for it.
- R7: A master is given `m_ready` only while it requests. When granted on a mapped slave, its `m_rdata` equals that slave's `s_rdata` in the same cycle.
- R8: An arbiter's rotation pointer moves only on a grant. Idle cycles leave it unchanged, so a master served alone still loses the next contention to the master following it in index order.
- R9: Synchronous active-low reset clears every pointer so that master 0 wins the first contention on any slave. While no master requests, all `s_valid` and `m_ready` outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_req | input | N_MST | Per-master transfer request |
| m_addr | input | N_MST*ADDR_W | Per-master address, master m at bits [m*ADDR_W +: ADDR_W] |
| m_write | input | N_MST | Per-master write flag (1 = write) |
| m_size | input | N_MST*SIZE_W | Per-master transfer size (0 byte, 1 half, 2 word) |
| m_wdata | input | N_MST*DATA_W | Per-master write data |
| m_ready | output | N_MST | Transfer completes this cycle (granted or error) |
| m_err | output | N_MST | Error response for an unmapped address |
| m_rdata | output | N_MST*DATA_W | Read data from the slave granted to the master |
| s_valid | output | N_SLV | Slave port carries a transfer this cycle |
| s_master | output | N_SLV*MID_W | Index of the master served on the slave port |
| s_addr | output | N_SLV*ADDR_W | Address forwarded to the slave |
| s_write | output | N_SLV | Write flag forwarded to the slave |
| s_size | output | N_SLV*SIZE_W | Size forwarded to the slave |
| s_wdata | output | N_SLV*DATA_W | Write data forwarded to the slave |
| s_rdata | input | N_SLV*DATA_W | Read data returned by each slave |

## Verification
The bench builds the matrix with three masters, four slaves, a 3-bit region field and 16-bit address and data paths. Three region bits over four slaves leave regions 4 to 7 unmapped, which makes the error path reachable next to normal traffic. Three masters make full three-way contention possible, so a complete rotation and the one-in-three service bound can be observed. Each slave model returns its address XOR a per-slave constant, so a misrouted read shows up at the master.

// File: rtl/xbar_pkg.sv
// Shared definitions for the round-robin bus matrix.
// Assumes: sizes fit in SIZE_W bits; master counts are small integers.
package xbar_pkg;
    localparam int SIZE_W = 2;

    typedef enum logic [SIZE_W-1:0] {
        XSZ_BYTE = 2'd0,
        XSZ_HALF = 2'd1,
        XSZ_WORD = 2'd2
    } xfer_size_e;

    // Index reached by stepping `off` places after `base` in a ring of `n`.
    function automatic int ring_step(input int base, input int off, input int n);
        return (base + off) % n;
    endfunction
endpackage

// File: rtl/xbar_decode.sv
// Address decoder for one master: picks a slave from the top REGION_W
// address bits. Region values at or above N_SLV are flagged as a miss.
// Assumes: one slave per region value, regions 0..N_SLV-1 mapped.
module xbar_decode #(
    parameter int N_SLV    = 4,
    parameter int ADDR_W   = 32,
    parameter int REGION_W = 3
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_SLV-1:0]  sel,
    output logic              miss
);
    logic [REGION_W-1:0] region;

    assign region = addr[ADDR_W-1 -: REGION_W];

    // Turn the region field into a one-hot select or a miss.
    always_comb begin
        sel  = '0;
        miss = 1'b0;
        if (req) begin
            if (int'(region) >= N_SLV) begin
                miss = 1'b1;
            end else begin
                for (int s = 0; s < N_SLV; s++) begin
                    sel[s] = (int'(region) == s);
                end
            end
        end
    end
endmodule

// File: rtl/xbar_rr_arb.sv
// Round-robin arbiter for one slave port. A single-cycle grant goes to the
// first requester found after the last master served, wrapping around.
// Assumes: grants are combinational; the pointer advances only on a grant.
module xbar_rr_arb #(
    parameter int N_MST = 3,
    parameter int MID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req,
    output logic [N_MST-1:0] gnt,
    output logic [MID_W-1:0] gnt_idx,
    output logic             gnt_any
);
    import xbar_pkg::*;

    logic [MID_W-1:0] last_q;

    // Search the ring starting one place after the last master served.
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int off = 1; off <= N_MST; off++) begin
            if (!gnt_any && req[ring_step(int'(last_q), off, N_MST)]) begin
                gnt_any = 1'b1;
                gnt[ring_step(int'(last_q), off, N_MST)] = 1'b1;
                gnt_idx = MID_W'(ring_step(int'(last_q), off, N_MST));
            end
        end
    end

    // Remember the master just served; reset makes master 0 win first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= MID_W'(N_MST - 1);
        end else if (gnt_any) begin
            last_q <= gnt_idx;
        end
    end
endmodule

// File: rtl/xbar_slv_port.sv
// One slave port of the matrix: arbitrates among the masters selecting it
// and forwards the winner's transfer attributes to the slave.
// Assumes: master buses are flat vectors indexed by master number.
module xbar_slv_port #(
    parameter int N_MST  = 3,
    parameter int MID_W  = 2,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_MST-1:0]          req,
    input  logic [N_MST*ADDR_W-1:0]   m_addr,
    input  logic [N_MST-1:0]          m_write,
    input  logic [N_MST*SIZE_W-1:0]   m_size,
    input  logic [N_MST*DATA_W-1:0]   m_wdata,
    output logic [N_MST-1:0]          gnt,
    output logic                      s_valid,
    output logic [MID_W-1:0]          s_master,
    output logic [ADDR_W-1:0]         s_addr,
    output logic                      s_write,
    output logic [SIZE_W-1:0]         s_size,
    output logic [DATA_W-1:0]         s_wdata
);
    logic [MID_W-1:0] win;
    logic             win_any;

    xbar_rr_arb #(
        .N_MST (N_MST),
        .MID_W (MID_W)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .gnt     (gnt),
        .gnt_idx (win),
        .gnt_any (win_any)
    );

    // Steer the winning master's attributes onto the slave port.
    always_comb begin
        s_valid  = win_any;
        s_master = win;
        s_addr   = '0;
        s_write  = 1'b0;
        s_size   = '0;
        s_wdata  = '0;
        if (win_any) begin
            s_addr  = m_addr[int'(win)*ADDR_W +: ADDR_W];
            s_write = m_write[win];
            s_size  = m_size[int'(win)*SIZE_W +: SIZE_W];
            s_wdata = m_wdata[int'(win)*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/xbar_rr_matrix.sv
// Multi-layer bus matrix: N_MST masters reach N_SLV slave ports, each slave
// port with its own round-robin arbiter and single-cycle grants. Unmapped
// addresses receive an immediate error response.
// Assumes: single-cycle slaves with combinational read data.
module xbar_rr_matrix #(
    parameter int N_MST    = 3,
    parameter int N_SLV    = 4,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int REGION_W = 3,
    parameter int SIZE_W   = xbar_pkg::SIZE_W,
    parameter int MID_W    = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_MST-1:0]          m_req,
    input  logic [N_MST*ADDR_W-1:0]   m_addr,
    input  logic [N_MST-1:0]          m_write,
    input  logic [N_MST*SIZE_W-1:0]   m_size,
    input  logic [N_MST*DATA_W-1:0]   m_wdata,
    output logic [N_MST-1:0]          m_ready,
    output logic [N_MST-1:0]          m_err,
    output logic [N_MST*DATA_W-1:0]   m_rdata,
    output logic [N_SLV-1:0]          s_valid,
    output logic [N_SLV*MID_W-1:0]    s_master,
    output logic [N_SLV*ADDR_W-1:0]   s_addr,
    output logic [N_SLV-1:0]          s_write,
    output logic [N_SLV*SIZE_W-1:0]   s_size,
    output logic [N_SLV*DATA_W-1:0]   s_wdata,
    input  logic [N_SLV*DATA_W-1:0]   s_rdata
);
    logic [N_SLV-1:0] sel_m [N_MST];
    logic [N_MST-1:0] miss;
    logic [N_MST-1:0] req_s [N_SLV];
    logic [N_MST-1:0] gnt_s [N_SLV];

    for (genvar m = 0; m < N_MST; m++) begin : g_dec
        xbar_decode #(
            .N_SLV    (N_SLV),
            .ADDR_W   (ADDR_W),
            .REGION_W (REGION_W)
        ) u_dec (
            .req  (m_req[m]),
            .addr (m_addr[m*ADDR_W +: ADDR_W]),
            .sel  (sel_m[m]),
            .miss (miss[m])
        );
    end

    // Regroup the per-master selects into per-slave request vectors.
    always_comb begin
        for (int s = 0; s < N_SLV; s++) begin
            for (int m = 0; m < N_MST; m++) begin
                req_s[s][m] = sel_m[m][s];
            end
        end
    end

    for (genvar s = 0; s < N_SLV; s++) begin : g_slv
        xbar_slv_port #(
            .N_MST  (N_MST),
            .MID_W  (MID_W),
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .SIZE_W (SIZE_W)
        ) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (req_s[s]),
            .m_addr   (m_addr),
            .m_write  (m_write),
            .m_size   (m_size),
            .m_wdata  (m_wdata),
            .gnt      (gnt_s[s]),
            .s_valid  (s_valid[s]),
            .s_master (s_master[s*MID_W +: MID_W]),
            .s_addr   (s_addr[s*ADDR_W +: ADDR_W]),
            .s_write  (s_write[s]),
            .s_size   (s_size[s*SIZE_W +: SIZE_W]),
            .s_wdata  (s_wdata[s*DATA_W +: DATA_W])
        );
    end

    // Build each master's response from its grant, miss and slave data.
    always_comb begin
        m_err   = miss;
        m_ready = miss;
        m_rdata = '0;
        for (int m = 0; m < N_MST; m++) begin
            for (int s = 0; s < N_SLV; s++) begin
                if (gnt_s[s][m]) begin
                    m_ready[m] = 1'b1;
                    m_rdata[m*DATA_W +: DATA_W] = s_rdata[s*DATA_W +: DATA_W];
                end
            end
        end
    end
endmodule

// File: rtl/xbar_rr_matrix_chk.sv
// Property checker for the bus matrix, bound to every instance.
// Assumes: observes ports only; keeps its own stall counters.
module xbar_rr_matrix_chk #(
    parameter int N_MST    = 3,
    parameter int N_SLV    = 4,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int REGION_W = 3,
    parameter int SIZE_W   = 2,
    parameter int MID_W    = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [N_MST-1:0]          m_req,
    input logic [N_MST*ADDR_W-1:0]   m_addr,
    input logic [N_MST-1:0]          m_write,
    input logic [N_MST*SIZE_W-1:0]   m_size,
    input logic [N_MST*DATA_W-1:0]   m_wdata,
    input logic [N_MST-1:0]          m_ready,
    input logic [N_MST-1:0]          m_err,
    input logic [N_MST*DATA_W-1:0]   m_rdata,
    input logic [N_SLV-1:0]          s_valid,
    input logic [N_SLV*MID_W-1:0]    s_master,
    input logic [N_SLV*ADDR_W-1:0]   s_addr,
    input logic [N_SLV-1:0]          s_write,
    input logic [N_SLV*SIZE_W-1:0]   s_size,
    input logic [N_SLV*DATA_W-1:0]   s_wdata,
    input logic [N_SLV*DATA_W-1:0]   s_rdata
);
    localparam int CNT_W = MID_W + 2;

    for (genvar m = 0; m < N_MST; m++) begin : g_m
        logic [CNT_W-1:0]  stall_cnt;
        logic [ADDR_W-1:0] prev_addr;
        logic              stalled;

        assign stalled = m_req[m] && !m_ready[m];

        // Count consecutive stalled cycles on an unchanged address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stall_cnt <= '0;
                prev_addr <= '0;
            end else begin
                prev_addr <= m_addr[m*ADDR_W +: ADDR_W];
                if (!stalled) begin
                    stall_cnt <= '0;
                end else if (m_addr[m*ADDR_W +: ADDR_W] != prev_addr) begin
                    stall_cnt <= CNT_W'(1);
                end else begin
                    stall_cnt <= stall_cnt + CNT_W'(1);
                end
            end
        end

        // R4: never N_MST stalls in a row on one target
        a_r4_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
            int'(stall_cnt) < N_MST);

        // R7: no completion without a request
        a_r7_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
            m_ready[m] |-> m_req[m]);

        // R2: a lone requester completes in the same cycle
        a_r2_lone_granted: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(m_req) == 1 && m_req[m]) |-> m_ready[m]);
    end

    for (genvar s = 0; s < N_SLV; s++) begin : g_s
        logic [MID_W-1:0] owner;
        assign owner = s_master[s*MID_W +: MID_W];

        // R5: the served master is requesting and sees its completion
        a_r5_owner_requests: assert property (@(posedge clk) disable iff (!rst_n)
            s_valid[s] |-> (m_req[owner] && m_ready[owner]));

        // R6: a master in error never occupies a slave port
        a_r6_err_no_slave: assert property (@(posedge clk) disable iff (!rst_n)
            s_valid[s] |-> !m_err[owner]);

        // R5: forwarded address belongs to the served master
        a_r5_addr_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
            s_valid[s] |-> (s_addr[s*ADDR_W +: ADDR_W] == m_addr[int'(owner)*ADDR_W +: ADDR_W]));
    end
endmodule

bind xbar_rr_matrix xbar_rr_matrix_chk #(
    .N_MST    (N_MST),
    .N_SLV    (N_SLV),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REGION_W (REGION_W),
    .SIZE_W   (SIZE_W),
    .MID_W    (MID_W)
) u_chk (.*);

// File: tb/xbar_rr_matrix_bench.sv
// Directed bench for the round-robin bus matrix; one task per scenario.
module xbar_rr_matrix_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_MST    = 3;
    localparam int N_SLV    = 4;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 16;
    localparam int REGION_W = 3;
    localparam int SIZE_W   = 2;
    localparam int MID_W    = 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [N_MST-1:0]        m_req = '0;
    logic [N_MST*ADDR_W-1:0] m_addr = '0;
    logic [N_MST-1:0]        m_write = '0;
    logic [N_MST*SIZE_W-1:0] m_size = '0;
    logic [N_MST*DATA_W-1:0] m_wdata = '0;
    logic [N_MST-1:0]        m_ready, m_err;
    logic [N_MST*DATA_W-1:0] m_rdata;
    logic [N_SLV-1:0]        s_valid, s_write;
    logic [N_SLV*MID_W-1:0]  s_master;
    logic [N_SLV*ADDR_W-1:0] s_addr;
    logic [N_SLV*SIZE_W-1:0] s_size;
    logic [N_SLV*DATA_W-1:0] s_wdata;
    logic [N_SLV*DATA_W-1:0] s_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbar_rr_matrix #(
        .N_MST(N_MST), .N_SLV(N_SLV), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .REGION_W(REGION_W), .SIZE_W(SIZE_W), .MID_W(MID_W)
    ) u_xbar_rr_matrix (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_addr(m_addr),
        .m_write(m_write), .m_size(m_size), .m_wdata(m_wdata),
        .m_ready(m_ready), .m_err(m_err), .m_rdata(m_rdata),
        .s_valid(s_valid), .s_master(s_master), .s_addr(s_addr),
        .s_write(s_write), .s_size(s_size), .s_wdata(s_wdata),
        .s_rdata(s_rdata)
    );

    // Slave models: read data is the address XOR a per-slave constant.
    function automatic logic [DATA_W-1:0] slave_word(int s, logic [ADDR_W-1:0] a);
        return DATA_W'(a) ^ DATA_W'(16'h1111 * (s + 1));
    endfunction

    always_comb begin
        for (int s = 0; s < N_SLV; s++) begin
            s_rdata[s*DATA_W +: DATA_W] = slave_word(s, s_addr[s*ADDR_W +: ADDR_W]);
        end
    end

    function automatic logic [ADDR_W-1:0] mk_addr(int region, int m);
        return {REGION_W'(region), (ADDR_W-REGION_W)'(16'h0100 * (m + 1) + 4)};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic next_cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input int m, input bit req, input int region,
                         input bit wr, input int sz, input int data);
        m_req[m] = req;
        m_addr[m*ADDR_W +: ADDR_W] = mk_addr(region, m);
        m_write[m] = wr;
        m_size[m*SIZE_W +: SIZE_W] = SIZE_W'(sz);
        m_wdata[m*DATA_W +: DATA_W] = DATA_W'(data);
    endtask

    task automatic do_reset();
        next_cyc();
        rst_n = 1'b0;
        m_req = '0; m_addr = '0; m_write = '0; m_size = '0; m_wdata = '0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // R9: quiet outputs after reset, master 0 wins first contention
    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(s_valid == '0, "R9 s_valid idle", int'(s_valid), 0);
        chk(m_ready == '0, "R9 m_ready idle", int'(m_ready), 0);
        next_cyc();
        for (int m = 0; m < N_MST; m++) drive(m, 1, 0, 0, 0, 0);
        @(negedge clk);
        chk(m_ready == 3'b001, "R9 first winner master 0", int'(m_ready), 1);
    endtask

    // R1/R7: disjoint targets all proceed with correct read data
    task automatic t_parallel();
        do_reset();
        next_cyc();
        for (int m = 0; m < N_MST; m++) drive(m, 1, m + 1, 0, 2, 0);
        @(negedge clk);
        chk(m_ready == 3'b111, "R1 all ready", int'(m_ready), 7);
        for (int m = 0; m < N_MST; m++) begin
            chk(s_master[(m+1)*MID_W +: MID_W] == MID_W'(m), "R1 slave owner",
                int'(s_master[(m+1)*MID_W +: MID_W]), m);
            chk(m_rdata[m*DATA_W +: DATA_W] == slave_word(m + 1, mk_addr(m + 1, m)),
                "R7 read data", int'(m_rdata[m*DATA_W +: DATA_W]),
                int'(slave_word(m + 1, mk_addr(m + 1, m))));
        end
    endtask

    // R3/R4/R5: three-way contention rotates 0,1,2,...
    task automatic t_rotate();
        int served [N_MST];
        do_reset();
        for (int m = 0; m < N_MST; m++) served[m] = 0;
        for (int c = 0; c < 6; c++) begin
            next_cyc();
            for (int m = 0; m < N_MST; m++) drive(m, 1, 1, 0, 1, 0);
            @(negedge clk);
            chk(m_ready == 3'(1 << (c % 3)), "R3 rotation order", int'(m_ready), 1 << (c % 3));
            chk(s_addr[1*ADDR_W +: ADDR_W] == mk_addr(1, c % 3), "R5 forwarded address",
                int'(s_addr[1*ADDR_W +: ADDR_W]), int'(mk_addr(1, c % 3)));
            for (int m = 0; m < N_MST; m++) if (m_ready[m]) served[m]++;
        end
        for (int m = 0; m < N_MST; m++)
            chk(served[m] == 2, "R4 served twice in six cycles", served[m], 2);
    endtask

    // R8: idle cycles keep the pointer; search resumes after last served
    task automatic t_skip();
        do_reset();
        next_cyc();
        drive(1, 1, 3, 0, 0, 0);
        @(negedge clk);
        chk(m_ready == 3'b010, "R8 lone master 1", int'(m_ready), 2);
        next_cyc();
        drive(1, 0, 3, 0, 0, 0);
        next_cyc();
        drive(0, 1, 3, 0, 0, 0);
        drive(2, 1, 3, 0, 0, 0);
        @(negedge clk);
        chk(m_ready == 3'b100, "R8 master 2 after 1", int'(m_ready), 4);
        next_cyc();
        @(negedge clk);
        chk(m_ready == 3'b001, "R8 then master 0", int'(m_ready), 1);
    endtask

    // R2: a lone master is served every cycle from the first
    task automatic t_alone();
        do_reset();
        for (int c = 0; c < 3; c++) begin
            next_cyc();
            drive(2, 1, 0, 0, 0, 0);
            @(negedge clk);
            chk(m_ready == 3'b100, "R2 lone master every cycle", int'(m_ready), 4);
        end
    endtask

    // R6: unmapped region errors at once and occupies no slave
    task automatic t_unmapped();
        do_reset();
        next_cyc();
        drive(0, 1, 5, 0, 0, 0);
        drive(1, 1, 0, 0, 0, 0);
        @(negedge clk);
        chk(m_ready == 3'b011, "R6 error completes with mapped", int'(m_ready), 3);
        chk(m_err == 3'b001, "R6 error only master 0", int'(m_err), 1);
        chk(s_valid == 4'b0001, "R6 only slave 0 busy", int'(s_valid), 1);
        chk(s_master[0 +: MID_W] == 2'd1, "R6 slave 0 serves master 1", int'(s_master[0 +: MID_W]), 1);
    endtask

    // R5: write attributes of the winner reach the slave port
    task automatic t_write();
        do_reset();
        next_cyc();
        drive(1, 1, 2, 1, 2, 16'hBEEF);
        @(negedge clk);
        chk(s_valid[2] && s_write[2], "R5 write flag", int'(s_write[2]), 1);
        chk(s_size[2*SIZE_W +: SIZE_W] == 2'd2, "R5 size word", int'(s_size[2*SIZE_W +: SIZE_W]), 2);
        chk(s_wdata[2*DATA_W +: DATA_W] == 16'hBEEF, "R5 write data",
            int'(s_wdata[2*DATA_W +: DATA_W]), 16'hBEEF);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_parallel();
        t_rotate();
        t_skip();
        t_alone();
        t_unmapped();
        t_write();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule